// File: doc/BRIEF.md
# Down-Counting Watchdog with Early-Warning Interrupt

This block is an independent watchdog timer. A 12-bit counter counts down once per prescaled tick. The tick is the core clock divided by a power of two. Software has to write a refresh key to the key register often enough to keep the counter away from zero. If the counter is already at zero when a tick arrives, the block raises a one-cycle reset request. The counter then reloads and the sequence repeats.

Before the reset request, an early-warning interrupt can fire. The interrupt is raised when the counter counts down into a programmed compare value. It has its own enable bit and a write-one acknowledge bit. Once raised, it stays high until software acknowledges it.

The prescaler, reload, window and early-warning fields are protected. They accept writes only after an access key has been written, and any other key write locks them again. A new prescaler or reload value takes effect a fixed number of cycles after it is written. Two status flags show that an update is still pending. Once started, the watchdog cannot be stopped.

Top module: `wdog_early`

Register map (byte offsets on `wr_addr` and `rd_addr`):

| Offset | Register | Fields |
|---|---|---|
| 0x00 | Key | Write only |
| 0x04 | Prescaler | Code in bits 3:0 |
| 0x08 | Reload | Value in bits 11:0 |
| 0x0C | Status | Bit 0 = prescaler update pending, bit 1 = reload update pending |
| 0x10 | Window | Value in bits 11:0, stored only |
| 0x14 | Early-warning control | Compare in bits 11:0, acknowledge in bit 14, enable in bit 15 |

Key values written to offset 0x00:

| Key | Action |
|---|---|
| 0x5555 | Opens write access |
| 0xCCCC | Starts the watchdog |
| 0xAAAA | Refreshes the counter |

## Requirements
- R1: After reset, the outputs and registers hold these values:
  - `rst_req` and `early_irq` are low.
  - Status reads 0.
  - Prescaler reads 0.
  - Reload and window read 0xFFF.
  - Early-warning control reads 0.
- R2: While access is locked, writes to the prescaler (0x04), reload (0x08), window (0x10) and the compare and enable fields of the early-warning register (0x14) are ignored. The read-back value does not change.
- R3: Writing key 0x5555 to 0x00 opens write access. Any other value written to 0x00 locks it again. Writes to registers other than the key register leave the access state unchanged.
- R4: A write to the prescaler sets status bit 0, and a write to the reload register sets status bit 1. Each flag reads 1 on the cycles after the write. It reads 0 from UPD_CYC (default 4) cycles after the write, when the new value becomes active.
- R5: Key 0xCCCC starts the watchdog. The counter loads the active reload value R and the prescaler clears. `rst_req` goes high for exactly one cycle, (R+1)*D cycles after the start write, where D is the division ratio.
- R6: Key 0xAAAA reloads the counter from the active reload value and clears the prescaler. The next reset request then comes (R+1)*D cycles after that write.
- R7: Prescaler code P selects D = 2^(P+2). Codes of 8 and above saturate at D = 1024.
- R8: With the enable bit (bit 15 of 0x14) set, `early_irq` rises (R-C)*D cycles after a start or refresh. C is the compare field in bits 11:0 of 0x14 and must be below R. This is the tick on which the counter counts down into C.
- R9: `early_irq` stays high until a write to 0x14 with bit 14 set. That acknowledge works whether access is open or locked, and it does not alter the compare or enable fields. The interrupt is not raised again until the next match.
- R10: With the enable bit clear, `early_irq` stays low through a whole countdown.
- R11: Once started, no key write stops the watchdog. The reset request still follows on schedule.
- R12: After a reset request, the counter reloads and the next request follows (R+1)*D cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read byte offset |
| rd_data | output | 16 | Combinational read data |
| rst_req | output | 1 | One-cycle reset request |
| early_irq | output | 1 | Early-warning interrupt, held until acknowledged |

## Verification
The hardest case to reach from the ports is changing the prescaler and reload values while the counter is already running. Each new value becomes active only after UPD_CYC cycles, and a tick under the old ratio can still land during that gap. Each random trial therefore reconfigures right after an observed reset request. It clears and disables the interrupt first, waits out the pending flags, re-enables with a fresh compare value, and then refreshes. The bench then predicts the interrupt and reset cycles from the new random ratio, reload and compare values. A directed run with code 9 and reload 2 covers the saturated 1024 divider.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_KEY = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_PRE = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RLD = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STS = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_WIN = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_EWC = 5'h14;

  localparam logic [15:0] KEY_KICK   = 16'hAAAA;
  localparam logic [15:0] KEY_UNLOCK = 16'h5555;
  localparam logic [15:0] KEY_START  = 16'hCCCC;

  localparam int EW_ACK_BIT = 14;
  localparam int EW_EN_BIT  = 15;

  typedef struct packed {
    logic start;
    logic kick;
    logic ack;
  } key_cmd_t;
endpackage

// File: rtl/wdg_shadow.sv
module wdg_shadow #(
  parameter int W = 12,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter int UPD_CYC = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] staged,
  output logic [W-1:0] active,
  output logic         pend
);
  localparam int DW = $clog2(UPD_CYC + 1);
  localparam logic [DW-1:0] DLY_INIT = DW'(UPD_CYC - 1);

  logic [W-1:0]  stage_q, stage_d, act_q, act_d;
  logic [DW-1:0] dly_q, dly_d;
  logic          pend_q, pend_d;

  always_comb begin
    stage_d = stage_q;
    act_d   = act_q;
    dly_d   = dly_q;
    pend_d  = pend_q;
    if (wr_en) begin
      stage_d = wr_val;
      pend_d  = 1'b1;
      dly_d   = DLY_INIT;
    end else if (pend_q) begin
      if (dly_q == '0) begin
        act_d  = stage_q;
        pend_d = 1'b0;
      end else begin
        dly_d = dly_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= RST_VAL;
      act_q   <= RST_VAL;
      dly_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      act_q   <= act_d;
      dly_q   <= dly_d;
      pend_q  <= pend_d;
    end
  end

  assign staged = stage_q;
  assign active = act_q;
  assign pend   = pend_q;

  p_write_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pend_q && stage_q == $past(wr_val)));
  p_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> (act_q == stage_q));
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PR_W = 4,
  parameter int MAX_LOG = 10,
  parameter int MIN_LOG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr,
  input  logic [PR_W-1:0] code,
  output logic            tick
);
  logic [MAX_LOG-1:0] pcnt_q, pcnt_d, mask;

  always_comb begin
    for (int i = 0; i < MAX_LOG; i++) begin
      mask[i] = (i < (int'(code) + MIN_LOG));
    end
  end

  assign tick = run && ((pcnt_q & mask) == mask);

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr)       pcnt_d = '0;
    else if (tick) pcnt_d = '0;
    else if (run)  pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             kick,
  input  logic             start,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] cmp,
  input  logic             ew_en,
  input  logic             ack,
  output logic             running,
  output logic             rst_req,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic run_q, run_d, rst_q, rst_d, irq_q, irq_d, load, hit;

  assign load = kick || start;
  assign hit  = run_q && tick && !load && (cnt_q != '0) &&
                ((cnt_q - 1'b1) == cmp) && ew_en;

  always_comb begin
    run_d = run_q || start;
    cnt_d = cnt_q;
    rst_d = 1'b0;
    if (load) begin
      cnt_d = reload_val;
    end else if (run_q && tick) begin
      if (cnt_q == '0) begin
        cnt_d = reload_val;
        rst_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (hit)      irq_d = 1'b1;
    else if (ack) irq_d = 1'b0;
    else          irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      run_q <= 1'b0;
      rst_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      rst_q <= rst_d;
      irq_q <= irq_d;
    end
  end

  assign running = run_q;
  assign rst_req = rst_q;
  assign irq     = irq_q;

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack) |=> irq_q);
  p_run_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_early.sv
module wdog_early
  import wdg_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 12,
  parameter int PR_W    = 4,
  parameter int MAX_LOG = 10,
  parameter int UPD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req,
  output logic              early_irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic unlock_q, unlock_d, key_wr, pr_wr, rld_wr, win_wr, ewc_wr;
  logic ew_en_q, ew_en_d, running, tick, pr_pend, rld_pend;
  logic [CNT_W-1:0] win_q, win_d, cmp_q, cmp_d, rld_stage, rld_act;
  logic [PR_W-1:0]  pr_stage, pr_act;
  key_cmd_t cmd;

  assign key_wr    = wr_en && (wr_addr == OFS_KEY);
  assign ewc_wr    = wr_en && (wr_addr == OFS_EWC);
  assign pr_wr     = wr_en && (wr_addr == OFS_PRE) && unlock_q;
  assign rld_wr    = wr_en && (wr_addr == OFS_RLD) && unlock_q;
  assign win_wr    = wr_en && (wr_addr == OFS_WIN) && unlock_q;
  assign cmd.start = key_wr && (wr_data[15:0] == KEY_START);
  assign cmd.kick  = key_wr && (wr_data[15:0] == KEY_KICK);
  assign cmd.ack   = ewc_wr && wr_data[EW_ACK_BIT];

  always_comb begin
    unlock_d = key_wr ? (wr_data[15:0] == KEY_UNLOCK) : unlock_q;
    win_d    = win_wr ? wr_data[CNT_W-1:0] : win_q;
    cmp_d    = cmp_q;
    ew_en_d  = ew_en_q;
    if (ewc_wr && unlock_q) begin
      cmp_d   = wr_data[CNT_W-1:0];
      ew_en_d = wr_data[EW_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b0;
      win_q    <= CNT_MAX;
      cmp_q    <= '0;
      ew_en_q  <= 1'b0;
    end else begin
      unlock_q <= unlock_d;
      win_q    <= win_d;
      cmp_q    <= cmp_d;
      ew_en_q  <= ew_en_d;
    end
  end

  wdg_shadow #(.W(PR_W), .RST_VAL('0), .UPD_CYC(UPD_CYC)) i_pr_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(pr_wr), .wr_val(wr_data[PR_W-1:0]),
    .staged(pr_stage), .active(pr_act), .pend(pr_pend));

  wdg_shadow #(.W(CNT_W), .RST_VAL(CNT_MAX), .UPD_CYC(UPD_CYC)) i_rld_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(rld_wr), .wr_val(wr_data[CNT_W-1:0]),
    .staged(rld_stage), .active(rld_act), .pend(rld_pend));

  wdg_prescaler #(.PR_W(PR_W), .MAX_LOG(MAX_LOG), .MIN_LOG(2)) i_prescaler (
    .clk(clk), .rst_n(rst_n), .run(running), .clr(cmd.start || cmd.kick),
    .code(pr_act), .tick(tick));

  wdg_core #(.CNT_W(CNT_W)) i_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(cmd.kick), .start(cmd.start),
    .reload_val(rld_act), .cmp(cmp_q), .ew_en(ew_en_q), .ack(cmd.ack),
    .running(running), .rst_req(rst_req), .irq(early_irq));

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_PRE: rd_data[PR_W-1:0] = pr_stage;
      OFS_RLD: rd_data[CNT_W-1:0] = rld_stage;
      OFS_STS: rd_data[1:0] = {rld_pend, pr_pend};
      OFS_WIN: rd_data[CNT_W-1:0] = win_q;
      OFS_EWC: begin
        rd_data[CNT_W-1:0] = cmp_q;
        rd_data[EW_EN_BIT] = ew_en_q;
      end
      default: rd_data = '0;
    endcase
  end

  p_locked_rld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_RLD && !unlock_q) |=> $stable(rld_stage));
  p_locked_ewc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ewc_wr && !unlock_q) |=> ($stable(cmp_q) && $stable(ew_en_q)));
  p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wr_data[15:0] != KEY_UNLOCK) |=> !unlock_q);
endmodule

// File: tb/test_wdog_early.sv
module test_wdog_early;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [4:0] wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic rst_req, early_irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam int UPD = 4;

  always #4 clk = ~clk;

  wdog_early i_wdog_early (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .rst_req(rst_req), .early_irq(early_irq));

  function automatic int div_of(input int code);
    int lg = code + 2;
    if (lg > 10) lg = 10;
    return 1 << lg;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output int d);
    rd_addr = a;
    #1;
    d = int'(rd_data);
  endtask

  task automatic measure(output int c_rst, output int c_irq);
    c_rst = -1; c_irq = -1;
    for (int c = 1; c <= 5000; c++) begin
      @(negedge clk);
      if (early_irq && c_irq < 0) c_irq = c;
      if (rst_req) begin c_rst = c; break; end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, cr, ci;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    check("R1 rst_req", int'(rst_req), 0);
    check("R1 irq", int'(early_irq), 0);
    rd(5'h0C, v); check("R1 status", v, 0);
    rd(5'h04, v); check("R1 prescaler", v, 0);
    rd(5'h08, v); check("R1 reload", v, 'hFFF);
    rd(5'h10, v); check("R1 window", v, 'hFFF);
    rd(5'h14, v); check("R1 ewc", v, 0);

    // R2: locked writes ignored
    wr(5'h08, 16'h0123);
    wr(5'h10, 16'h0077);
    rd(5'h08, v); check("R2 reload locked", v, 'hFFF);
    rd(5'h10, v); check("R2 window locked", v, 'hFFF);
    rd(5'h0C, v); check("R2 no pending", v, 0);

    // R3/R4: unlock, write, pending flags
    wr(5'h00, 16'h5555);
    wr(5'h08, 16'h0005);
    rd(5'h08, v); check("R3 reload unlocked", v, 5);
    rd(5'h0C, v); check("R4 reload pending", v, 2);
    repeat (UPD) @(negedge clk);
    rd(5'h0C, v); check("R4 reload settled", v, 0);
    wr(5'h04, 16'h0000);
    rd(5'h0C, v); check("R4 prescaler pending", v, 1);
    repeat (UPD) @(negedge clk);
    rd(5'h0C, v); check("R4 prescaler settled", v, 0);
    wr(5'h10, 16'h0040);
    rd(5'h10, v); check("R3 window unlocked", v, 'h40);
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0007);
    rd(5'h08, v); check("R3 relocked", v, 5);

    // R5/R8: start with compare 2, reload 5, divide 4
    wr(5'h00, 16'h5555);
    wr(5'h14, 16'h8002);
    wr(5'h00, 16'hCCCC);
    measure(cr, ci);
    check("R8 irq time", ci, 12);
    check("R5 rst time", cr, 24);
    check("R9 irq held", int'(early_irq), 1);
    // R9: acknowledge while locked
    wr(5'h14, 16'h4000);
    check("R5 one-cycle pulse", int'(rst_req), 0);
    check("R9 irq cleared", int'(early_irq), 0);
    rd(5'h14, v); check("R9 fields kept", v, 'h8002);
    // R12: periodic
    measure(cr, ci);
    check("R12 next rst", cr, 23);
    check("R9 re-raised on match", ci, 11);

    // R6: refresh
    wr(5'h14, 16'h4000);
    repeat (5) @(negedge clk);
    wr(5'h00, 16'hAAAA);
    measure(cr, ci);
    check("R6 irq after kick", ci, 12);
    check("R6 rst after kick", cr, 24);

    // R11: other key writes do not stop it
    wr(5'h14, 16'h4000);
    wr(5'h00, 16'h0000);
    measure(cr, ci);
    check("R11 still runs", cr, 22);
    check("R11 irq", ci, 10);

    // R10: enable clear
    wr(5'h00, 16'h5555);
    wr(5'h14, 16'h4002);
    measure(cr, ci);
    check("R10 no irq", ci, -1);
    check("R10 rst", cr, 22);

    // R7: saturated prescaler
    wr(5'h00, 16'h5555);
    wr(5'h04, 16'h0009);
    wr(5'h08, 16'h0002);
    repeat (UPD) @(negedge clk);
    wr(5'h00, 16'hAAAA);
    measure(cr, ci);
    check("R7 divide 1024", cr, 3 * 1024);

    // Random trials (R5, R7, R8)
    void'($urandom(32'd7));
    for (int t = 0; t < 8; t++) begin
      int code = $urandom_range(0, 2);
      int r = $urandom_range(4, 20);
      int cmpv = $urandom_range(0, r - 1);
      int d = div_of(code);
      wr(5'h00, 16'h5555);
      wr(5'h14, 16'h4000);
      wr(5'h04, 16'(code));
      wr(5'h08, 16'(r));
      repeat (UPD) @(negedge clk);
      wr(5'h14, 16'hC000 | 16'(cmpv));
      wr(5'h00, 16'hAAAA);
      measure(cr, ci);
      check("R8 random irq", ci, (r - cmpv) * d);
      check("R5 random rst", cr, (r + 1) * d);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule